// File: doc/BRIEF.md
# Bidirectional Dual-Clock Buffer with Mailbox Bypass

This block links two sides, A and B, that each run on their own free-running clock. The clocks may be unrelated or the same clock. Two separate first-in first-out stores of 64 words by 36 bits carry traffic between the sides. One store moves words from A to B and the other moves words from B to A. A side only acts on the rising edge of its own clock, and only when one of its enables asks for a write, a read, a mailbox access or an offset load.

Each direction also has a one-word mailbox. The mailbox carries a single 36-bit word past the queue. A "mail waiting" flag at the receiving side shows that the word is there.

For every queue, the side that writes it sees full and almost-full flags, and the side that reads it sees empty and almost-empty flags. Each side can program the almost thresholds of the two flags it sees.

Each 36-bit word is four 9-bit lanes, and the top bit of each lane is its parity bit. Incoming data is checked for parity and any error is only reported, never acted on. Each side can choose to have the parity bits of the data it reads regenerated.

Top module: `duplex_fifo_mbx`

## Requirements
- R1: While `rst_n` is low, and after it is released, both queues are empty: `a_empty`, `b_empty`, `a_aempty` and `b_aempty` are 1, and `a_full`, `b_full`, `a_afull` and `b_afull` are 0. Both mail flags are 0, both `*_dout` registers are 0, and all four almost offsets are 8.
- R2: Words written at A with `a_wr_en` while `a_full` is 0 come out at B in write order. Each word appears on `b_dout` after the `clk_b` edge on which `b_rd_en` is high while `b_empty` is 0.
- R3: Words written at B with `b_wr_en` while `b_full` is 0 come out at A in write order, with the same read timing as R2.
- R4: After 64 writes that have not been read, the writer's full flag is 1. A write while full is dropped: it never shows up at the reading side.
- R5: A read while the queue is empty changes neither `*_dout` nor the queue. Empty only rises after a local read.
- R6: The writer's almost-full flag is 1 exactly when the stored count is at least 64 minus that side's almost-full offset. With the reset offset of 8, it rises on the 56th stored word.
- R7: The reader's almost-empty flag is 1 exactly when the stored count is at most that side's almost-empty offset. With the offset of 8, it is 1 with 8 words stored and 0 with 9.
- R8: A `clk` edge with `*_ofs_ld` high loads two offsets from that side's data input. Bits [6:0] become the almost-full offset of the queue this side writes. Bits [22:16] become the almost-empty offset of the queue this side reads.
- R9: A `*_mb_wr` edge stores the data word in the mailbox toward the other side, and that side's mail flag then rises.
- R10: The mail flag clears on the edge after a `*_mb_rd` read, which loads the word into `*_dout`. A mailbox write made while the previous word has not yet been read is dropped.
- R11: When `*_mb_rd` and `*_rd_en` are both high while mail is waiting, only the mailbox is read and the queue is left untouched.
- R12: `*_par_err` is 1 in the same cycle as any lane of `*_din` whose 9 bits have an XOR different from `par_odd`. Here `par_odd` = 0 means even parity and 1 means odd parity. The lane bits are [8:0], [17:9], [26:18] and [35:27].
- R13: With `*_par_gen` = 1, the word loaded into `*_dout` has bits 8, 17, 26 and 35 replaced. Each becomes the XOR of the eight lower bits of its lane, XORed with `par_odd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| a_din | input | 36 | Side A write, mailbox and offset data |
| a_wr_en | input | 1 | Push into the A-to-B queue |
| a_rd_en | input | 1 | Pop from the B-to-A queue |
| a_mb_wr | input | 1 | Write the A-to-B mailbox |
| a_mb_rd | input | 1 | Read the B-to-A mailbox |
| a_ofs_ld | input | 1 | Load side A offsets from a_din |
| a_par_gen | input | 1 | Regenerate parity on side A reads |
| a_dout | output | 36 | Side A read register |
| a_full | output | 1 | A-to-B queue full |
| a_afull | output | 1 | A-to-B queue almost full |
| a_empty | output | 1 | B-to-A queue empty |
| a_aempty | output | 1 | B-to-A queue almost empty |
| a_mail_new | output | 1 | Mail from B waiting |
| a_par_err | output | 1 | Parity error on a_din |
| b_din | input | 36 | Side B write, mailbox and offset data |
| b_wr_en | input | 1 | Push into the B-to-A queue |
| b_rd_en | input | 1 | Pop from the A-to-B queue |
| b_mb_wr | input | 1 | Write the B-to-A mailbox |
| b_mb_rd | input | 1 | Read the A-to-B mailbox |
| b_ofs_ld | input | 1 | Load side B offsets from b_din |
| b_par_gen | input | 1 | Regenerate parity on side B reads |
| b_dout | output | 36 | Side B read register |
| b_full | output | 1 | B-to-A queue full |
| b_afull | output | 1 | B-to-A queue almost full |
| b_empty | output | 1 | A-to-B queue empty |
| b_aempty | output | 1 | A-to-B queue almost empty |
| b_mail_new | output | 1 | Mail from A waiting |
| b_par_err | output | 1 | Parity error on b_din |

## Verification
Some results are due in the same or the next cycle:
- Writer-side full and almost-full change just after the writer's own edge.
- Read data and a cleared mail flag are in `*_dout` and the flag one edge of the reader's clock after the read.
- `*_par_err` follows `*_din` in the same cycle.

Empty, almost-empty and the mail flag at the receiving side change only after two edges of the receiving clock, following the sender's edge.

The bench drives inputs and samples outputs on falling edges. Same-domain results are read at the first falling edge after the active edge. Cross-domain flags are read only after a margin of eight receiving-clock cycles. The scoreboard monitor compares each popped word one falling edge after the edge that read it.

// File: rtl/dfm_pkg.sv
`timescale 1ns/1ps
package dfm_pkg;
   localparam int unsigned LANE_W = 9;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_FIFO = 2'd1,
      RD_MAIL = 2'd2
   } rd_src_e;

   function automatic logic lane_fill(input logic [LANE_W-2:0] data, input logic odd);
      return (^data) ^ odd;
   endfunction
endpackage

// File: rtl/dfm_sync.sv
`timescale 1ns/1ps
module dfm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dfm_fifo.sv
`timescale 1ns/1ps
module dfm_fifo #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned STAGES = 2,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned PW    = AW + 1
) (
   input  logic             rst_n,
   input  logic             wclk,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PW-1:0]    af_ofs,
   output logic             full,
   output logic             afull,
   input  logic             rclk,
   input  logic             rd_en,
   input  logic [PW-1:0]    ae_ofs,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             aempty
);
   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_w, wgray_r, rbin_w, wbin_r;
   logic [PW-1:0] wcnt, rcnt;
   logic          wr_go, rd_go;

   // write domain
   assign wr_go = wr_en && !full;

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_go) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end

   always_ff @(posedge wclk)
      if (wr_go) mem[wbin[AW-1:0]] <= wdata;

   dfm_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

   assign rbin_w = from_gray(rgray_w);
   assign wcnt   = wbin - rbin_w;
   assign full   = (wcnt == PW'(DEPTH));
   assign afull  = ({1'b0, wcnt} + {1'b0, af_ofs}) >= (PW+1)'(DEPTH);

   // read domain
   assign rd_go = rd_en && !empty;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_go) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end

   dfm_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   assign wbin_r = from_gray(wgray_r);
   assign rcnt   = wbin_r - rbin;
   assign empty  = (rcnt == '0);
   assign aempty = (rcnt <= ae_ofs);
   assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/dfm_mailbox.sv
`timescale 1ns/1ps
module dfm_mailbox #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             put_en,
   input  logic [WIDTH-1:0] put_data,
   input  logic             rclk,
   input  logic             take_en,
   output logic [WIDTH-1:0] rdata,
   output logic             mail_new
);
   logic put_tgl, get_tgl, get_s, put_r, busy;

   dfm_sync #(.W(1), .STAGES(STAGES)) u_get_sync (
      .clk(sclk), .rst_n(rst_n), .d(get_tgl), .q(get_s));
   dfm_sync #(.W(1), .STAGES(STAGES)) u_put_sync (
      .clk(rclk), .rst_n(rst_n), .d(put_tgl), .q(put_r));

   assign busy = put_tgl ^ get_s;

   always_ff @(posedge sclk or negedge rst_n)
      if (!rst_n) begin
         put_tgl <= 1'b0;
         rdata   <= '0;
      end else if (put_en && !busy) begin
         put_tgl <= ~put_tgl;
         rdata   <= put_data;
      end

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n)       get_tgl <= 1'b0;
      else if (take_en) get_tgl <= ~get_tgl;

   assign mail_new = put_r ^ get_tgl;
endmodule

// File: rtl/dfm_port.sv
`timescale 1ns/1ps
module dfm_port
   import dfm_pkg::*;
#(
   parameter int unsigned WIDTH     = 36,
   parameter int unsigned OFS_W     = 7,
   parameter int unsigned OFS_RESET = 8,
   parameter int unsigned AE_LSB    = 16,
   parameter bit          GEN_BUILD = 1'b1,
   localparam int unsigned LANES    = WIDTH / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic             par_odd,
   input  logic             par_gen,
   input  logic             ofs_ld,
   input  logic             rd_en,
   input  logic             mb_rd,
   input  logic             mail_new,
   input  logic             fifo_empty,
   input  logic [WIDTH-1:0] fifo_rdata,
   input  logic [WIDTH-1:0] mail_rdata,
   output logic             par_err,
   output logic [OFS_W-1:0] af_ofs,
   output logic [OFS_W-1:0] ae_ofs,
   output logic             fifo_rd_req,
   output logic             mail_take,
   output logic [WIDTH-1:0] dout
);
   rd_src_e          src;
   logic [WIDTH-1:0] sel_word, out_word;
   logic [LANES-1:0] lane_bad;

   // offset registers
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         af_ofs <= OFS_W'(OFS_RESET);
         ae_ofs <= OFS_W'(OFS_RESET);
      end else if (ofs_ld) begin
         af_ofs <= din[OFS_W-1:0];
         ae_ofs <= din[AE_LSB +: OFS_W];
      end

   // read source choice: mailbox has priority over the queue
   assign fifo_rd_req = rd_en && !(mb_rd && mail_new);

   always_comb begin
      if (mb_rd && mail_new)              src = RD_MAIL;
      else if (rd_en && !fifo_empty)      src = RD_FIFO;
      else                                src = RD_NONE;
   end

   assign mail_take = (src == RD_MAIL);
   assign sel_word  = (src == RD_MAIL) ? mail_rdata : fifo_rdata;

   // passive parity check
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_chk
         assign lane_bad[k] = (^din[k*LANE_W +: LANE_W]) ^ par_odd;
      end
   endgenerate
   assign par_err = |lane_bad;

   // optional parity regeneration on the read path
   generate
      if (GEN_BUILD) begin : g_gen
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign out_word[k*LANE_W +: LANE_W-1] = sel_word[k*LANE_W +: LANE_W-1];
            assign out_word[k*LANE_W + LANE_W-1]  = par_gen
               ? lane_fill(sel_word[k*LANE_W +: LANE_W-1], par_odd)
               : sel_word[k*LANE_W + LANE_W-1];
         end
      end else begin : g_pass
         logic unused_gen;
         assign unused_gen = par_gen;
         assign out_word   = sel_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               dout <= '0;
      else if (src != RD_NONE)  dout <= out_word;
endmodule

// File: rtl/duplex_fifo_mbx.sv
`timescale 1ns/1ps
module duplex_fifo_mbx #(
   parameter int unsigned WIDTH       = 36,
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_RESET   = 8,
   parameter bit          GEN_BUILD   = 1'b1
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_n,
   input  logic             par_odd,
   input  logic [WIDTH-1:0] a_din,
   input  logic             a_wr_en,
   input  logic             a_rd_en,
   input  logic             a_mb_wr,
   input  logic             a_mb_rd,
   input  logic             a_ofs_ld,
   input  logic             a_par_gen,
   output logic [WIDTH-1:0] a_dout,
   output logic             a_full,
   output logic             a_afull,
   output logic             a_empty,
   output logic             a_aempty,
   output logic             a_mail_new,
   output logic             a_par_err,
   input  logic [WIDTH-1:0] b_din,
   input  logic             b_wr_en,
   input  logic             b_rd_en,
   input  logic             b_mb_wr,
   input  logic             b_mb_rd,
   input  logic             b_ofs_ld,
   input  logic             b_par_gen,
   output logic [WIDTH-1:0] b_dout,
   output logic             b_full,
   output logic             b_afull,
   output logic             b_empty,
   output logic             b_aempty,
   output logic             b_mail_new,
   output logic             b_par_err
);
   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned OFS_W  = AW + 1;
   localparam int unsigned AE_LSB = 16;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (WIDTH % dfm_pkg::LANE_W != 0) begin : g_bad_width
         $error("WIDTH must be a whole number of 9-bit lanes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (OFS_RESET >= DEPTH) begin : g_bad_ofs
         $error("OFS_RESET must be below DEPTH");
      end
      if (AE_LSB + OFS_W > WIDTH || OFS_W > AE_LSB) begin : g_bad_field
         $error("offset fields do not fit the data word");
      end
   endgenerate

   logic [OFS_W-1:0] a_af_ofs, a_ae_ofs, b_af_ofs, b_ae_ofs;
   logic [WIDTH-1:0] ab_rdata, ba_rdata, ab_mail, ba_mail;
   logic             a_fifo_req, b_fifo_req, a_take, b_take;

   dfm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_ab (
      .rst_n(rst_n),
      .wclk(clk_a), .wr_en(a_wr_en), .wdata(a_din), .af_ofs(a_af_ofs),
      .full(a_full), .afull(a_afull),
      .rclk(clk_b), .rd_en(b_fifo_req), .ae_ofs(b_ae_ofs),
      .rdata(ab_rdata), .empty(b_empty), .aempty(b_aempty));

   dfm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_ba (
      .rst_n(rst_n),
      .wclk(clk_b), .wr_en(b_wr_en), .wdata(b_din), .af_ofs(b_af_ofs),
      .full(b_full), .afull(b_afull),
      .rclk(clk_a), .rd_en(a_fifo_req), .ae_ofs(a_ae_ofs),
      .rdata(ba_rdata), .empty(a_empty), .aempty(a_aempty));

   dfm_mailbox #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_mb_ab (
      .rst_n(rst_n),
      .sclk(clk_a), .put_en(a_mb_wr), .put_data(a_din),
      .rclk(clk_b), .take_en(b_take), .rdata(ab_mail), .mail_new(b_mail_new));

   dfm_mailbox #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_mb_ba (
      .rst_n(rst_n),
      .sclk(clk_b), .put_en(b_mb_wr), .put_data(b_din),
      .rclk(clk_a), .take_en(a_take), .rdata(ba_mail), .mail_new(a_mail_new));

   dfm_port #(.WIDTH(WIDTH), .OFS_W(OFS_W), .OFS_RESET(OFS_RESET),
              .AE_LSB(AE_LSB), .GEN_BUILD(GEN_BUILD)) u_port_a (
      .clk(clk_a), .rst_n(rst_n), .din(a_din), .par_odd(par_odd),
      .par_gen(a_par_gen), .ofs_ld(a_ofs_ld), .rd_en(a_rd_en),
      .mb_rd(a_mb_rd), .mail_new(a_mail_new), .fifo_empty(a_empty),
      .fifo_rdata(ba_rdata), .mail_rdata(ba_mail), .par_err(a_par_err),
      .af_ofs(a_af_ofs), .ae_ofs(a_ae_ofs), .fifo_rd_req(a_fifo_req),
      .mail_take(a_take), .dout(a_dout));

   dfm_port #(.WIDTH(WIDTH), .OFS_W(OFS_W), .OFS_RESET(OFS_RESET),
              .AE_LSB(AE_LSB), .GEN_BUILD(GEN_BUILD)) u_port_b (
      .clk(clk_b), .rst_n(rst_n), .din(b_din), .par_odd(par_odd),
      .par_gen(b_par_gen), .ofs_ld(b_ofs_ld), .rd_en(b_rd_en),
      .mb_rd(b_mb_rd), .mail_new(b_mail_new), .fifo_empty(b_empty),
      .fifo_rdata(ab_rdata), .mail_rdata(ab_mail), .par_err(b_par_err),
      .af_ofs(b_af_ofs), .ae_ofs(b_ae_ofs), .fifo_rd_req(b_fifo_req),
      .mail_take(b_take), .dout(b_dout));
endmodule

// File: rtl/dfm_chk.sv
`timescale 1ns/1ps
module dfm_chk #(
   parameter int unsigned WIDTH = 36
) (
   input logic             clk_a,
   input logic             clk_b,
   input logic             rst_n,
   input logic             a_wr_en,
   input logic             a_rd_en,
   input logic             a_mb_rd,
   input logic [WIDTH-1:0] a_dout,
   input logic             a_full,
   input logic             a_afull,
   input logic             a_empty,
   input logic             a_aempty,
   input logic             a_mail_new,
   input logic             b_wr_en,
   input logic             b_rd_en,
   input logic             b_mb_rd,
   input logic [WIDTH-1:0] b_dout,
   input logic             b_full,
   input logic             b_afull,
   input logic             b_empty,
   input logic             b_aempty,
   input logic             b_mail_new
);
   // R4: full can only rise after a local write
   assert_full_by_write_R4_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      $rose(a_full) |-> $past(a_wr_en));
   assert_full_by_write_R4_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      $rose(b_full) |-> $past(b_wr_en));

   // R5: empty can only rise after a local read
   assert_empty_by_read_R5_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      $rose(a_empty) |-> $past(a_rd_en));
   assert_empty_by_read_R5_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      $rose(b_empty) |-> $past(b_rd_en));

   // R5: the read register holds when no read is accepted
   assert_dout_hold_R5_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!(a_rd_en && !a_empty) && !(a_mb_rd && a_mail_new)) |=> $stable(a_dout));
   assert_dout_hold_R5_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      (!(b_rd_en && !b_empty) && !(b_mb_rd && b_mail_new)) |=> $stable(b_dout));

   // R6: full implies almost full
   assert_full_in_afull_R6_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_full |-> a_afull);
   assert_full_in_afull_R6_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_full |-> b_afull);

   // R7: empty implies almost empty
   assert_empty_in_aempty_R7_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_empty |-> a_aempty);
   assert_empty_in_aempty_R7_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_empty |-> b_aempty);

   // R10: a mailbox read clears the flag on the next edge, nothing else does
   assert_mail_clear_R10_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_mail_new && a_mb_rd) |=> !a_mail_new);
   assert_mail_clear_R10_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_mail_new && b_mb_rd) |=> !b_mail_new);
   assert_mail_fall_R10_a: assert property (@(posedge clk_a) disable iff (!rst_n)
      $fell(a_mail_new) |-> $past(a_mb_rd));
   assert_mail_fall_R10_b: assert property (@(posedge clk_b) disable iff (!rst_n)
      $fell(b_mail_new) |-> $past(b_mb_rd));
endmodule

bind duplex_fifo_mbx dfm_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
   .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_mb_rd(a_mb_rd), .a_dout(a_dout),
   .a_full(a_full), .a_afull(a_afull), .a_empty(a_empty), .a_aempty(a_aempty),
   .a_mail_new(a_mail_new),
   .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_mb_rd(b_mb_rd), .b_dout(b_dout),
   .b_full(b_full), .b_afull(b_afull), .b_empty(b_empty), .b_aempty(b_aempty),
   .b_mail_new(b_mail_new));

// File: tb/sim_duplex_fifo_mbx.sv
`timescale 1ns/1ps
module sim_duplex_fifo_mbx;
   logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0, par_odd = 1'b0;
   logic [35:0] a_din = '0, b_din = '0;
   logic a_wr_en = 0, a_mb_wr = 0, a_mb_rd = 0, a_ofs_ld = 0, a_par_gen = 0;
   logic b_wr_en = 0, b_mb_wr = 0, b_mb_rd = 0, b_ofs_ld = 0, b_par_gen = 0;
   logic a_rd_en, b_rd_en;
   logic mon_rd_a = 0, mon_rd_b = 0, frc_rd_a = 0, frc_rd_b = 0;
   logic drain_a = 0, drain_b = 0;
   logic [35:0] a_dout, b_dout;
   logic a_full, a_afull, a_empty, a_aempty, a_mail_new, a_par_err;
   logic b_full, b_afull, b_empty, b_aempty, b_mail_new, b_par_err;

   int total = 0, bad = 0;
   logic [35:0] qab[$], qba[$];

   assign a_rd_en = mon_rd_a | frc_rd_a;
   assign b_rd_en = mon_rd_b | frc_rd_b;

   always #2.5 clk_a = ~clk_a;
   always #3.5 clk_b = ~clk_b;

   duplex_fifo_mbx u0 (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .par_odd(par_odd),
      .a_din(a_din), .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_mb_wr(a_mb_wr),
      .a_mb_rd(a_mb_rd), .a_ofs_ld(a_ofs_ld), .a_par_gen(a_par_gen),
      .a_dout(a_dout), .a_full(a_full), .a_afull(a_afull), .a_empty(a_empty),
      .a_aempty(a_aempty), .a_mail_new(a_mail_new), .a_par_err(a_par_err),
      .b_din(b_din), .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_mb_wr(b_mb_wr),
      .b_mb_rd(b_mb_rd), .b_ofs_ld(b_ofs_ld), .b_par_gen(b_par_gen),
      .b_dout(b_dout), .b_full(b_full), .b_afull(b_afull), .b_empty(b_empty),
      .b_aempty(b_aempty), .b_mail_new(b_mail_new), .b_par_err(b_par_err));

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_a(input logic [35:0] w);
      @(negedge clk_a);
      while (a_full) @(negedge clk_a);
      a_din = w; a_wr_en = 1'b1; qab.push_back(w);
      @(negedge clk_a);
      a_wr_en = 1'b0;
   endtask

   task automatic push_b(input logic [35:0] w);
      @(negedge clk_b);
      while (b_full) @(negedge clk_b);
      b_din = w; b_wr_en = 1'b1; qba.push_back(w);
      @(negedge clk_b);
      b_wr_en = 1'b0;
   endtask

   function automatic logic [35:0] gen_exp(input logic [35:0] w, input logic odd);
      logic [35:0] r = w;
      for (int k = 0; k < 4; k++) r[k*9+8] = (^w[k*9 +: 8]) ^ odd;
      return r;
   endfunction

   // scoreboard monitors
   initial begin : mon_b
      logic pend = 1'b0;
      forever begin
         @(negedge clk_b);
         if (pend) begin
            if (qab.size() == 0) chk("R2 unexpected word at B", b_dout, 'x);
            else chk("R2 A-to-B order", b_dout, qab.pop_front());
         end
         pend = drain_b && !b_empty;
         mon_rd_b = pend;
      end
   end

   initial begin : mon_a
      logic pend = 1'b0;
      forever begin
         @(negedge clk_a);
         if (pend) begin
            if (qba.size() == 0) chk("R3 unexpected word at A", a_dout, 'x);
            else chk("R3 B-to-A order", a_dout, qba.pop_front());
         end
         pend = drain_a && !a_empty;
         mon_rd_a = pend;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk_a);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [35:0] v, w;
      repeat (4) @(negedge clk_a);
      // R1 reset state
      chk("R1 a_empty", 36'(a_empty), 36'd1);
      chk("R1 b_empty", 36'(b_empty), 36'd1);
      chk("R1 full flags", {34'd0, a_full, b_full}, 36'd0);
      chk("R1 almost flags", {32'd0, a_afull, b_afull, a_aempty, b_aempty}, 36'h3);
      chk("R1 mail flags", {34'd0, a_mail_new, b_mail_new}, 36'd0);
      chk("R1 a_dout", a_dout, 36'd0);
      chk("R1 b_dout", b_dout, 36'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk_b);
      chk("R1 after release empty", {34'd0, a_empty, b_empty}, 36'h3);

      // R2 / R3 streaming both ways with random words
      drain_a = 1; drain_b = 1;
      fork
         for (int i = 0; i < 20; i++) push_a({4'($urandom), 32'($urandom)});
         for (int i = 0; i < 20; i++) push_b({4'($urandom), 32'($urandom)});
      join
      wait (qab.size() == 0 && qba.size() == 0);
      drain_a = 0; drain_b = 0;
      repeat (4) @(negedge clk_b);

      // R8 program side A: almost-full 2, almost-empty 3
      @(negedge clk_a);
      a_din = '0; a_din[6:0] = 7'd2; a_din[22:16] = 7'd3; a_ofs_ld = 1;
      @(negedge clk_a);
      a_ofs_ld = 0; a_din = '0;

      // R8 / R4 fill A-to-B with no reads
      for (int i = 1; i <= 64; i++) begin
         push_a(36'h100000000 + 36'(i));
         if (i == 61) chk("R8 a_afull at 61 words (ofs 2)", 36'(a_afull), 36'd0);
         if (i == 62) chk("R8 a_afull at 62 words (ofs 2)", 36'(a_afull), 36'd1);
         if (i == 63) chk("R4 a_full at 63 words", 36'(a_full), 36'd0);
      end
      chk("R4 a_full at 64 words", 36'(a_full), 36'd1);
      @(negedge clk_a);
      a_din = 36'hDEAD; a_wr_en = 1;   // dropped write
      @(negedge clk_a);
      a_wr_en = 0;
      drain_b = 1;
      wait (qab.size() == 0);
      repeat (10) @(negedge clk_b);
      chk("R4 dropped word never read", 36'(b_empty), 36'd1);
      drain_b = 0;
      repeat (3) @(negedge clk_b);

      // R8 almost-empty at A (ofs 3) and R6 almost-full at B (ofs 8)
      for (int i = 1; i <= 56; i++) begin
         push_b(36'h200000000 + 36'(i));
         if (i == 3) begin
            repeat (8) @(negedge clk_a);
            chk("R8 a_aempty with 3 words (ofs 3)", {35'd0, a_aempty}, 36'd1);
            chk("R8 a_empty with 3 words", {35'd0, a_empty}, 36'd0);
         end
         if (i == 4) begin
            repeat (8) @(negedge clk_a);
            chk("R8 a_aempty with 4 words (ofs 3)", {35'd0, a_aempty}, 36'd0);
         end
         if (i == 55) chk("R6 b_afull at 55 words", 36'(b_afull), 36'd0);
         if (i == 56) chk("R6 b_afull at 56 words", 36'(b_afull), 36'd1);
      end
      drain_a = 1;
      wait (qba.size() == 0);
      drain_a = 0;
      repeat (4) @(negedge clk_a);

      // R7 almost-empty at B with the reset offset of 8
      for (int i = 1; i <= 9; i++) begin
         push_a(36'h300000000 + 36'(i));
         if (i == 8) begin
            repeat (8) @(negedge clk_b);
            chk("R7 b_aempty with 8 words", {35'd0, b_aempty}, 36'd1);
         end
      end
      repeat (8) @(negedge clk_b);
      chk("R7 b_aempty with 9 words", {35'd0, b_aempty}, 36'd0);
      drain_b = 1;
      wait (qab.size() == 0);
      drain_b = 0;
      repeat (4) @(negedge clk_b);

      // R5 read while empty
      v = b_dout;
      @(negedge clk_b); frc_rd_b = 1;
      repeat (3) @(negedge clk_b);
      frc_rd_b = 0;
      chk("R5 b_dout held on empty read", b_dout, v);
      chk("R5 b_empty still set", {35'd0, b_empty}, 36'd1);

      // R9 / R10 mailbox A to B, second write while full is dropped
      @(negedge clk_a); a_din = 36'h0AAAA5555; a_mb_wr = 1;
      @(negedge clk_a); a_din = 36'h0BBBB6666;
      @(negedge clk_a); a_mb_wr = 0; a_din = '0;
      repeat (8) @(negedge clk_b);
      chk("R9 b_mail_new raised", {35'd0, b_mail_new}, 36'd1);
      b_mb_rd = 1;
      @(negedge clk_b); b_mb_rd = 0;
      chk("R9 mailbox word at b_dout", b_dout, 36'h0AAAA5555);
      chk("R10 b_mail_new cleared", {35'd0, b_mail_new}, 36'd0);
      repeat (12) @(negedge clk_b);
      chk("R10 write to full mailbox dropped", {35'd0, b_mail_new}, 36'd0);

      // R11 mailbox priority at A over a waiting queue word
      push_b(36'h4_1234_5678);
      void'(qba.pop_back());
      @(negedge clk_b); b_din = 36'h5_CAFE_0001; b_mb_wr = 1;
      @(negedge clk_b); b_mb_wr = 0; b_din = '0;
      repeat (8) @(negedge clk_a);
      chk("R9 a_mail_new raised", {35'd0, a_mail_new}, 36'd1);
      a_mb_rd = 1; frc_rd_a = 1;
      @(negedge clk_a); a_mb_rd = 0; frc_rd_a = 0;
      chk("R11 mailbox wins", a_dout, 36'h5_CAFE_0001);
      chk("R11 queue untouched", {35'd0, a_empty}, 36'd0);
      chk("R10 a_mail_new cleared", {35'd0, a_mail_new}, 36'd0);
      frc_rd_a = 1;
      @(negedge clk_a); frc_rd_a = 0;
      chk("R11 queue word after mailbox", a_dout, 36'h4_1234_5678);
      chk("R11 queue now empty", {35'd0, a_empty}, 36'd1);

      // R12 passive parity check
      @(negedge clk_a);
      a_din = 36'h0; b_din = 36'h1;
      #1;
      chk("R12 even clean word", {35'd0, a_par_err}, 36'd0);
      chk("R12 even bad lane0 at B", {35'd0, b_par_err}, 36'd1);
      a_din = 36'h0_0000_0200;   // bit 9: lane 1 odd
      #1;
      chk("R12 even bad lane1", {35'd0, a_par_err}, 36'd1);
      par_odd = 1; a_din = 36'h804020100;
      #1;
      chk("R12 odd clean word", {35'd0, a_par_err}, 36'd0);
      a_din = 36'h0;
      #1;
      chk("R12 odd zero word flagged", {35'd0, a_par_err}, 36'd1);
      par_odd = 0; b_din = '0;

      // R13 parity generation at B, even then odd
      w = {1'b0, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h03, 1'b0, 8'h01};
      b_par_gen = 1;
      for (int p = 0; p < 2; p++) begin
         push_a(w);
         void'(qab.pop_back());
         par_odd = p[0];
         repeat (8) @(negedge clk_b);
         frc_rd_b = 1;
         @(negedge clk_b); frc_rd_b = 0;
         chk(p == 0 ? "R13 even parity regenerated" : "R13 odd parity regenerated",
             b_dout, gen_exp(w, p[0]));
      end
      b_par_gen = 0; par_odd = 0;

      repeat (4) @(negedge clk_a);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule